// File: doc/BRIEF.md
# Row-Zone Write-Protect Controller

This block decides, one request at a time, whether a write into a 256-byte array (16 rows of 16 bytes) or into an 8-bit protect register may proceed. The protect register holds a zone-select bit and a row pointer. The zone-select bit chooses whether the locked zone is the low end or the high end of the array. The row pointer marks where that zone ends or begins. A hardware lock pin enables protection. The pin is ignored until the register has been programmed once after reset, so a part whose lock pin is tied high can still receive its first configuration in place.

Requests arrive on a single strobe-qualified port that carries a target select (array or register), a direction, an address and write data. The block answers in the same cycle with either a grant or an error. It forwards granted array writes to an external array as a write enable. It also returns the register contents for granted register reads. The array storage, its read data path and the serial bus framing all sit outside this block.

Top module: `wp_guard`

## Requirements
- R1: After reset the protect register holds 00h and the programmed flag is clear. A register read with the lock pin low returns 00h.
- R2: While the flag is clear, protection is inactive. Array writes are granted at any address, and a register write is granted even when the lock pin is high.
- R3: Once the flag is set, every register write made while the lock pin is high is denied with an error.
- R4: When the register's bit 7 is 0, protection is active (flag set and pin high) and the register's bits 6..0 hold pointer P (P ≤ 15), array writes to addresses below P×16 are denied and all others are granted. With P = 0, every address is writable.
- R5: When bit 7 is 1, protection is active and P ≤ 15, array writes to addresses at or above P×16 are denied. With P = 0, every address is locked.
- R6: A pointer above 15 locks the whole array in either mode while protection is active.
- R7: With the lock pin low, every write is granted. This includes register writes of any 8-bit value, bit 7 among them, and the value written is then read back.
- R8: Array reads (req_write = 0, req_target = 0) are always granted, whatever the register value, flag or pin.
- R9: A register read (req_write = 0, req_target = 1) is granted with the register value on rd_data only while the lock pin is low. Otherwise it gets an error, and rd_data is 00h.
- R10: A denied request raises req_error for exactly the cycle its strobe is sampled, keeps mem_we low, and leaves the register unchanged.
- R11: The first granted register write sets the programmed flag, even when the value written is 00h. Only reset clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_pin | input | 1 | Hardware write-lock input; high requests protection |
| req_valid | input | 1 | Request strobe, sampled each clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_target | input | 1 | 0 = array, 1 = protect register |
| req_addr | input | 8 | Array byte address |
| req_wdata | input | 8 | Write data |
| req_grant | output | 1 | Request accepted this cycle |
| req_error | output | 1 | Request refused this cycle |
| mem_we | output | 1 | Write enable to the external array |
| mem_addr | output | 8 | Array address to the external array |
| mem_wdata | output | 8 | Write data to the external array |
| rd_data | output | 8 | Register contents for a granted register read, else 00h |
| reg_readable | output | 1 | High while a register read would be granted |

## Verification
Two functions can fall on the same cycle. One is the first register write accepted under a high lock pin. The other is the arming of protection, which that same write causes by setting the programmed flag. The bench holds the pin high and issues the one-shot write, first with a non-zero value and, after a fresh reset, with 00h. It requires a grant on that cycle and an error on the very next register write, and it checks array grants against a boundary model computed from address arithmetic. A denial is judged both at req_error and mem_we in the strobe cycle, and by reading the register back afterwards with the pin low.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  typedef enum logic {
    TGT_ARRAY = 1'b0,
    TGT_PROT  = 1'b1
  } tgt_e;

  typedef struct packed {
    logic reg_wr_ok;
    logic arr_wr_ok;
    logic reg_rd_ok;
    logic arr_rd_ok;
  } accept_t;

endpackage

// File: rtl/wpg_prot_reg.sv
module wpg_prot_reg #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] prot_q,
  output logic             prog_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= '0;
      prog_q <= 1'b0;
    end else if (wr_en) begin
      prot_q <= wr_data;
      prog_q <= 1'b1;
    end
  end

  // R11: once set, the flag stays until reset
  p_prog_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    prog_q |=> prog_q);

  // R1: an unprogrammed register still holds its delivery value
  p_delivery_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_q |-> (prot_q == '0));

endmodule

// File: rtl/wpg_zone_decode.sv
module wpg_zone_decode #(
  parameter int ADDR_W   = 8,
  parameter int ROW_LOG2 = 4,
  parameter int REG_W    = 8
) (
  input  logic [REG_W-1:0]  prot,
  input  logic [ADDR_W-1:0] addr,
  output logic              in_zone
);

  localparam int ROW_W    = ADDR_W - ROW_LOG2;
  localparam int NUM_ROWS = 1 << ROW_W;
  localparam int PTR_W    = REG_W - 1;
  localparam logic [PTR_W-1:0] ROW_LIMIT = PTR_W'(NUM_ROWS);

  logic             top_mode;
  logic [PTR_W-1:0] ptr;
  logic             ptr_over;
  logic [NUM_ROWS-1:0] row_lock;
  logic [ROW_W-1:0] row_idx;

  assign top_mode = prot[REG_W-1];
  assign ptr      = prot[PTR_W-1:0];
  assign ptr_over = (ptr >= ROW_LIMIT);
  assign row_idx  = addr[ADDR_W-1:ROW_LOG2];

  // Row r lies inside the zone for the given mode and pointer
  function automatic logic zone_hit(input logic top, input logic [PTR_W-1:0] p,
                                    input logic over, input logic [PTR_W-1:0] row);
    if (over)     return 1'b1;
    else if (top) return (row >= p);
    else          return (row < p);
  endfunction

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign row_lock[r] = zone_hit(top_mode, ptr, ptr_over, PTR_W'(r));
  end

  assign in_zone = row_lock[row_idx];

  always_comb begin
    // R5: top mode with a zero pointer covers every row
    if (top_mode && ptr == '0) p_top_zero_r5: assert (in_zone);
    // R4: bottom mode with a zero pointer covers nothing
    if (!top_mode && ptr == '0) p_bottom_zero_r4: assert (!in_zone);
    // R6: an out-of-range pointer covers everything
    if (ptr_over) p_ptr_over_r6: assert (in_zone);
  end

endmodule

// File: rtl/wpg_access_ctrl.sv
module wpg_access_ctrl
  import wpg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    req_write,
  input  tgt_e    req_tgt,
  input  logic    lock_pin,
  input  logic    prog_q,
  input  logic    in_zone,
  output accept_t acc,
  output logic    grant,
  output logic    error,
  output logic    reg_readable
);

  logic wr_req, rd_req, prot_active, to_reg;

  assign wr_req      = req_valid && req_write;
  assign rd_req      = req_valid && !req_write;
  assign to_reg      = (req_tgt == TGT_PROT);
  assign prot_active = prog_q && lock_pin;

  assign acc.reg_wr_ok = wr_req && to_reg && !prot_active;
  assign acc.arr_wr_ok = wr_req && !to_reg && !(prot_active && in_zone);
  assign acc.reg_rd_ok = rd_req && to_reg && !lock_pin;
  assign acc.arr_rd_ok = rd_req && !to_reg;

  assign grant        = |acc;
  assign error        = req_valid && !grant;
  assign reg_readable = !lock_pin;

  // R8: array reads are never refused
  p_array_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_tgt == TGT_ARRAY) |-> (grant && !error));

  // R9: register reads are refused while the pin is high
  p_reg_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_tgt == TGT_PROT && lock_pin) |-> error);

  // R3: programmed and pinned means the register is frozen
  p_locked_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_q && lock_pin && req_valid && req_write && req_tgt == TGT_PROT)
      |-> (error && !acc.reg_wr_ok));

  // R7: a low pin admits every write
  p_unlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_pin && req_valid && req_write) |-> grant);

  // R2: the first register write always goes through
  p_one_shot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_q && req_valid && req_write && req_tgt == TGT_PROT) |-> acc.reg_wr_ok);

endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wpg_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int ROW_LOG2 = 4,
  parameter int REG_W    = 8,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_pin,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_target,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_grant,
  output logic              req_error,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [REG_W-1:0]  rd_data,
  output logic              reg_readable
);

  tgt_e             tgt;
  accept_t          acc;
  logic [REG_W-1:0] prot_q;
  logic             prog_q;
  logic             in_zone;
  logic             reg_wr_evt;
  logic             arr_wr_evt;
  logic             reg_rd_evt;
  logic             deny_evt;

  assign tgt = tgt_e'(req_target);

  wpg_zone_decode #(
    .ADDR_W(ADDR_W), .ROW_LOG2(ROW_LOG2), .REG_W(REG_W)
  ) u_zone (
    .prot(prot_q), .addr(req_addr), .in_zone(in_zone)
  );

  wpg_access_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_tgt(tgt),
    .lock_pin(lock_pin), .prog_q(prog_q), .in_zone(in_zone),
    .acc(acc), .grant(req_grant), .error(deny_evt),
    .reg_readable(reg_readable)
  );

  assign reg_wr_evt = acc.reg_wr_ok;
  assign arr_wr_evt = acc.arr_wr_ok;
  assign reg_rd_evt = acc.reg_rd_ok;

  wpg_prot_reg #(.REG_W(REG_W)) u_preg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_evt), .wr_data(req_wdata[REG_W-1:0]),
    .prot_q(prot_q), .prog_q(prog_q)
  );

  assign req_error = deny_evt;
  assign mem_we    = arr_wr_evt;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;
  assign rd_data   = reg_rd_evt ? prot_q : '0;

  // R10: a refused register write leaves the register as it was
  p_reg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (deny_evt && req_write && req_target) |=> $stable(prot_q));

  // R10: a refusal never reaches the array
  p_deny_no_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
    deny_evt |-> !mem_we);

  // R11: a granted register write arms the flag on the next cycle
  p_first_arm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_evt |=> prog_q);

endmodule

// File: tb/wp_guard_tb.sv
module wp_guard_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       lock_pin;
  logic       req_valid, req_write, req_target;
  logic [7:0] req_addr, req_wdata;
  logic       req_grant, req_error, mem_we, reg_readable;
  logic [7:0] mem_addr, mem_wdata, rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wp_guard u_dut (
    .clk(clk), .rst_n(rst_n), .lock_pin(lock_pin),
    .req_valid(req_valid), .req_write(req_write), .req_target(req_target),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_grant(req_grant), .req_error(req_error), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_data(rd_data),
    .reg_readable(reg_readable)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Locked-address model: boundary = pointer * 16 bytes
  function automatic bit model_locked(logic [7:0] pr, int addr);
    int p     = int'(pr[6:0]);
    int bound = p * 16;
    if (p > 15) return 1'b1;
    if (pr[7])  return addr >= bound;
    return addr < bound;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_target = 1'b0;
    req_addr = '0; req_wdata = '0; lock_pin = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Issue one request, check its same-cycle answer, then an idle cycle
  task automatic do_req(bit tgt, bit wr, int addr, int data, bit exp_grant,
                        int exp_rd, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_target = tgt;
    req_addr = 8'(addr); req_wdata = 8'(data);
    #1;
    check(tag, "grant", int'(req_grant), int'(exp_grant));
    check(tag, "error", int'(req_error), int'(!exp_grant));
    check(tag, "mem_we", int'(mem_we), int'(exp_grant && wr && !tgt));
    if (!wr && tgt) check(tag, "rd_data", int'(rd_data), exp_rd);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(tag, "error idle", int'(req_error), 0);
  endtask

  task automatic set_pin(bit v);
    @(negedge clk);
    lock_pin = v;
  endtask

  task automatic prog_reg(int v);  // with pin low, R7
    set_pin(1'b0);
    do_req(1'b1, 1'b1, 0, v, 1'b1, 0, "R7");
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R1", "readable", int'(reg_readable), 1);
    do_req(1'b1, 1'b0, 0, 0, 1'b1, 8'h00, "R1");
  endtask

  task automatic t_unprogrammed();
    do_reset();
    set_pin(1'b1);
    do_req(1'b0, 1'b1, 8'h00, 8'h11, 1'b1, 0, "R2");
    do_req(1'b0, 1'b1, 8'hFF, 8'h22, 1'b1, 0, "R2");
    do_req(1'b1, 1'b0, 0, 0, 1'b0, 8'h00, "R9");
    do_req(1'b1, 1'b1, 0, 8'h83, 1'b1, 0, "R2");
    do_req(1'b1, 1'b1, 0, 8'h05, 1'b0, 0, "R3");
    set_pin(1'b0);
    do_req(1'b1, 1'b0, 0, 0, 1'b1, 8'h83, "R10");
  endtask

  task automatic zone_sweep(int pr, string tag);
    prog_reg(pr);
    set_pin(1'b1);
    foreach (sweep_addrs[i])
      do_req(1'b0, 1'b1, sweep_addrs[i], 8'hA5,
             !model_locked(8'(pr), sweep_addrs[i]), 0, tag);
  endtask

  int sweep_addrs[6] = '{8'h00, 8'h2F, 8'h30, 8'h3F, 8'h40, 8'hFF};

  task automatic t_zones();
    zone_sweep(8'h83, "R5");
    zone_sweep(8'h04, "R4");
    zone_sweep(8'h00, "R4");
    zone_sweep(8'h80, "R5");
    zone_sweep(8'h10, "R6");
    zone_sweep(8'h90, "R6");
  endtask

  task automatic t_unlock_and_reads();
    set_pin(1'b1);
    do_req(1'b0, 1'b0, 8'h00, 0, 1'b1, 0, "R8");
    do_req(1'b0, 1'b0, 8'hFF, 0, 1'b1, 0, "R8");
    #1 check("R9", "readable high pin", int'(reg_readable), 0);
    set_pin(1'b0);
    do_req(1'b0, 1'b1, 8'h00, 8'h5A, 1'b1, 0, "R7");
    do_req(1'b1, 1'b1, 0, 8'h7F, 1'b1, 0, "R7");
    do_req(1'b1, 1'b0, 0, 0, 1'b1, 8'h7F, "R7");
    do_req(1'b1, 1'b1, 0, 8'hFF, 1'b1, 0, "R7");
    do_req(1'b1, 1'b0, 0, 0, 1'b1, 8'hFF, "R9");
  endtask

  task automatic t_zero_program();
    do_reset();
    set_pin(1'b1);
    do_req(1'b1, 1'b1, 0, 8'h00, 1'b1, 0, "R11");
    do_req(1'b1, 1'b1, 0, 8'h01, 1'b0, 0, "R11");
    do_req(1'b0, 1'b1, 8'h00, 8'h33, 1'b1, 0, "R11");
    set_pin(1'b0);
    do_req(1'b1, 1'b0, 0, 0, 1'b1, 8'h00, "R10");
  endtask

  initial begin
    rst_n = 1'b0; lock_pin = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_target = 1'b0; req_addr = '0; req_wdata = '0;
    t_reset();
    t_unprogrammed();
    t_zones();
    t_unlock_and_reads();
    t_zero_program();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule